// File: doc/BRIEF.md
# Immediate-Form Add/Subtract Execute Slice

This block is one execute slice of a 64-bit load/store core. Each cycle it can accept one instruction word with a valid bit, the value of the source register and the program counter. It decodes the word into one of five immediate-form operations: add a shifted immediate, add a shifted immediate to the address of the next instruction, add an immediate with carry (plain or record form), and subtract the source from an immediate with carry. All five share one adder. The subtract form is fed the inverted source and a carry-in of one.

One clock edge after the input, the slice presents a registered result with its own write-enable. It also presents the carry pair, the signed-overflow pair and a four-bit condition field (less, greater, equal, summary-overflow), and each of the two flag groups has its own write-enable. Any outputs that are not written keep their last value. A word that matches none of the five operations raises an illegal flag and writes nothing.

The decoder works in one state per operation: `OP_ADD_SHIFTED`, `OP_ADD_PC`, `OP_ADD_CARRY`, `OP_SUB_CARRY` and `OP_NONE`. The operation is chosen from the opcode in instruction bits 31:26, plus bits 5:1 for the PC form. No state is carried between instructions, so every decode starts fresh from the current word.

Top module: `imm_alu_exec`

## Requirements
- R1: Outputs appear exactly one clock after the input: `valid_out` is the previous cycle's `valid_in`. A synchronous active-high reset clears `valid_out`, `illegal_out`, every write-enable and every held output. A cycle with `valid_in` low writes nothing.
- R2: Opcode 15 (bits 31:26) selects add-shifted. The result is `src_in` plus the sign-extended immediate in bits 15:0 shifted left by 16, taken modulo 2^64.
- R3: Opcode 19 with bits 5:1 equal to 00010 selects add-PC. A signed 16-bit value d is assembled with d[0] = instr[0], d[5:1] = instr[20:16] and d[15:6] = instr[15:6]. The result is `pc_in` + 4 + (sign-extended d shifted left by 16), modulo 2^64.
- R4: Opcode 12 (plain) and opcode 13 (record form) select add-carrying. The result is `src_in` plus the sign-extended bits 15:0.
- R5: Opcode 8 selects subtract-from-immediate. The result is the bitwise inverse of `src_in`, plus the sign-extended bits 15:0, plus 1.
- R6: For the carrying forms, `ca_out` is the carry out of bit 63 of the sum, including the injected one. `ca32_out` is the carry out of bit 31 of the low-half sum, including the injected one.
- R7: For the carrying forms, `ov_out` is set when the signed 64-bit sum leaves the 64-bit two's-complement range. `ov32_out` is set the same way for the signed sum of the low 32 bits.
- R8: The condition field is written only when instruction bit 26 is set, which is the record form (opcode 13). When written, exactly one of less/greater/equal is set, from a signed comparison of the result with zero, and summary-overflow equals the computed 64-bit overflow. Otherwise `cr_we` is low and the field keeps its value.
- R9: The add-shifted and add-PC forms leave `flags_we` low, and the carry and overflow outputs keep their values. The carrying forms raise `flags_we`.
- R10: A valid word that matches no operation sets `illegal_out` and leaves every write-enable low. This includes opcode 19 with other bits 5:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Instruction word is present |
| instr_in | input | 32 | Instruction word |
| src_in | input | 64 | Source register value |
| pc_in | input | 64 | Address of the instruction |
| valid_out | output | 1 | Outputs belong to an instruction |
| illegal_out | output | 1 | Instruction word not supported |
| result_out | output | 64 | Result value |
| result_we | output | 1 | Result write-enable |
| ca_out | output | 1 | Carry out of bit 63 |
| ca32_out | output | 1 | Carry out of bit 31 |
| ov_out | output | 1 | Signed 64-bit overflow |
| ov32_out | output | 1 | Signed 32-bit overflow |
| flags_we | output | 1 | Carry/overflow write-enable |
| cr_lt | output | 1 | Result below zero |
| cr_gt | output | 1 | Result above zero |
| cr_eq | output | 1 | Result equal to zero |
| cr_so | output | 1 | Summary overflow |
| cr_we | output | 1 | Condition field write-enable |

## Verification
The bench builds the slice with its default parameters: a 64-bit datapath, a 32-bit half boundary and a 16-bit immediate shifted by 16. With these, the 32-bit and 64-bit carry and overflow points are separate bits, so one operand can set one flag of a pair and leave the other clear. The source values zero, alternating bits and all-ones, together with the immediates 0, 1, -1, 0x7FFF, 0x8000 and 0x100, reach both sign-extension polarities, wrap-around at both boundaries and a zero result. The PC is fixed at 0x1000, which makes the add-PC results easy to check.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD_SHIFTED,
        OP_ADD_PC,
        OP_ADD_CARRY,
        OP_SUB_CARRY
    } imm_op_e;

    localparam int unsigned ILEN = 32;

    localparam logic [5:0] PRIM_ADD_SHIFTED = 6'd15;
    localparam logic [5:0] PRIM_ADD_PC      = 6'd19;
    localparam logic [4:0] EXT_ADD_PC       = 5'd2;
    localparam logic [5:0] PRIM_ADDC        = 6'd12;
    localparam logic [5:0] PRIM_ADDC_REC    = 6'd13;
    localparam logic [5:0] PRIM_SUBC        = 6'd8;

endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
    import imm_alu_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned SHIFT = 16
) (
    input  logic [ILEN-1:0] instr,
    output imm_op_e         op,
    output logic            record_form,
    output logic [XLEN-1:0] imm_ext
);
    localparam int unsigned HIGH_PAD = XLEN - IMM_W - SHIFT;
    localparam int unsigned LOW_PAD  = XLEN - IMM_W;

    logic [5:0]       prim;
    logic [IMM_W-1:0] field_imm;
    logic [IMM_W-1:0] pc_imm;
    logic             unused_dest;

    assign prim        = instr[31:26];
    assign field_imm   = instr[IMM_W-1:0];
    assign pc_imm      = {instr[15:6], instr[20:16], instr[0]};
    assign unused_dest = ^instr[25:21];

    always_comb begin
        op          = OP_NONE;
        record_form = 1'b0;
        unique case (prim)
            PRIM_ADD_SHIFTED: op = OP_ADD_SHIFTED;
            PRIM_ADD_PC:      op = (instr[5:1] == EXT_ADD_PC) ? OP_ADD_PC : OP_NONE;
            PRIM_ADDC:        op = OP_ADD_CARRY;
            PRIM_ADDC_REC: begin
                op          = OP_ADD_CARRY;
                record_form = instr[26];
            end
            PRIM_SUBC:        op = OP_SUB_CARRY;
            default:          op = OP_NONE;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_ADD_SHIFTED: imm_ext = {{HIGH_PAD{field_imm[IMM_W-1]}}, field_imm, {SHIFT{1'b0}}};
            OP_ADD_PC:      imm_ext = {{HIGH_PAD{pc_imm[IMM_W-1]}}, pc_imm, {SHIFT{1'b0}}};
            OP_ADD_CARRY,
            OP_SUB_CARRY:   imm_ext = {{LOW_PAD{field_imm[IMM_W-1]}}, field_imm};
            default:        imm_ext = '0;
        endcase
    end

endmodule

// File: rtl/imm_alu_adder.sv
module imm_alu_adder #(
    parameter int unsigned W    = 64,
    parameter int unsigned HALF = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         carry_half,
    output logic         ovf,
    output logic         ovf_half
);
    logic [W:0]    full_sum;
    logic [HALF:0] half_sum;

    assign full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign half_sum = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};

    assign sum        = full_sum[W-1:0];
    assign carry      = full_sum[W];
    assign carry_half = half_sum[HALF];
    assign ovf        = (a[W-1] == b[W-1]) && (full_sum[W-1] != a[W-1]);
    assign ovf_half   = (a[HALF-1] == b[HALF-1]) && (half_sum[HALF-1] != a[HALF-1]);

endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
    import imm_alu_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned HALF  = 32,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned SHIFT = 16,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_in,
    input  logic [31:0]     instr_in,
    input  logic [XLEN-1:0] src_in,
    input  logic [XLEN-1:0] pc_in,
    output logic            valid_out,
    output logic            illegal_out,
    output logic [XLEN-1:0] result_out,
    output logic            result_we,
    output logic            ca_out,
    output logic            ca32_out,
    output logic            ov_out,
    output logic            ov32_out,
    output logic            flags_we,
    output logic            cr_lt,
    output logic            cr_gt,
    output logic            cr_eq,
    output logic            cr_so,
    output logic            cr_we
);
    localparam logic [XLEN-1:0] NEXT_OFFSET = XLEN'(INSN_BYTES);

    imm_op_e         op;
    logic            record_form;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opa;
    logic            cin;
    logic [XLEN-1:0] sum;
    logic            carry, carry_half, ovf, ovf_half;
    logic            legal, do_result, do_flags, do_cr;

    imm_alu_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .SHIFT(SHIFT)) decode_i (
        .instr       (instr_in),
        .op          (op),
        .record_form (record_form),
        .imm_ext     (imm_ext)
    );

    always_comb begin
        opa   = src_in;
        cin   = 1'b0;
        legal = 1'b1;
        unique case (op)
            OP_ADD_SHIFTED: opa = src_in;
            OP_ADD_PC:      opa = pc_in + NEXT_OFFSET;
            OP_ADD_CARRY:   opa = src_in;
            OP_SUB_CARRY: begin
                opa = ~src_in;
                cin = 1'b1;
            end
            default:        legal = 1'b0;
        endcase
    end

    imm_alu_adder #(.W(XLEN), .HALF(HALF)) adder_i (
        .a          (opa),
        .b          (imm_ext),
        .cin        (cin),
        .sum        (sum),
        .carry      (carry),
        .carry_half (carry_half),
        .ovf        (ovf),
        .ovf_half   (ovf_half)
    );

    assign do_result = valid_in && legal;
    assign do_flags  = do_result && (op == OP_ADD_CARRY || op == OP_SUB_CARRY);
    assign do_cr     = do_flags && record_form;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out   <= 1'b0;
            illegal_out <= 1'b0;
            result_we   <= 1'b0;
            flags_we    <= 1'b0;
            cr_we       <= 1'b0;
        end else begin
            valid_out   <= valid_in;
            illegal_out <= valid_in && !legal;
            result_we   <= do_result;
            flags_we    <= do_flags;
            cr_we       <= do_cr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_out <= '0;
            ca_out     <= 1'b0;
            ca32_out   <= 1'b0;
            ov_out     <= 1'b0;
            ov32_out   <= 1'b0;
            cr_lt      <= 1'b0;
            cr_gt      <= 1'b0;
            cr_eq      <= 1'b0;
            cr_so      <= 1'b0;
        end else begin
            if (do_result) result_out <= sum;
            if (do_flags) begin
                ca_out   <= carry;
                ca32_out <= carry_half;
                ov_out   <= ovf;
                ov32_out <= ovf_half;
            end
            if (do_cr) begin
                cr_lt <= sum[XLEN-1];
                cr_eq <= (sum == '0);
                cr_gt <= !sum[XLEN-1] && (sum != '0);
                cr_so <= ovf;
            end
        end
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    // R1
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> !result_we && !flags_we && !cr_we && !illegal_out);
    // R10
    illegal_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_out |-> !result_we && !flags_we && !cr_we);
    // R8
    cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ($countones({cr_lt, cr_gt, cr_eq}) == 1) && flags_we);
    // R8
    cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cr_we |-> $stable({cr_lt, cr_gt, cr_eq, cr_so}));
    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flags_we |-> $stable({ca_out, ca32_out, ov_out, ov32_out}));

endmodule

// File: tb/imm_alu_exec_tb_top.sv
`timescale 1ns/1ps
module imm_alu_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic [31:0] instr_in;
    logic [63:0] src_in, pc_in;
    logic        valid_out, illegal_out, result_we, flags_we, cr_we;
    logic [63:0] result_out;
    logic        ca_out, ca32_out, ov_out, ov32_out;
    logic        cr_lt, cr_gt, cr_eq, cr_so;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [63:0] PC_FIXED = 64'h1000;
    localparam logic [31:0] OP_WORDS [5] = '{32'h3C64_0000, 32'h4C60_0004,
                                             32'h3064_0000, 32'h3464_0000, 32'h2064_0000};
    localparam logic [63:0] SRC_VALS [3] = '{64'h0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [15:0] IMM_VALS [6] = '{16'h0000, 16'h0001, 16'hFFFF,
                                             16'h7FFF, 16'h8000, 16'h0100};

    logic [3:0] m_flags;
    logic [3:0] m_cr;

    always #4 clk = ~clk;

    imm_alu_exec dut_i (
        .clk(clk), .rst(rst), .valid_in(valid_in), .instr_in(instr_in),
        .src_in(src_in), .pc_in(pc_in), .valid_out(valid_out),
        .illegal_out(illegal_out), .result_out(result_out), .result_we(result_we),
        .ca_out(ca_out), .ca32_out(ca32_out), .ov_out(ov_out), .ov32_out(ov32_out),
        .flags_we(flags_we), .cr_lt(cr_lt), .cr_gt(cr_gt), .cr_eq(cr_eq),
        .cr_so(cr_so), .cr_we(cr_we)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] encode(input int op, input logic [15:0] imm);
        if (op == 1)
            return OP_WORDS[op] | {16'h0, imm[15:6], 6'h0} | {11'h0, imm[5:1], 16'h0} | {31'h0, imm[0]};
        return OP_WORDS[op] | {16'h0, imm};
    endfunction

    task automatic reference(input int op, input logic [63:0] src, input logic [15:0] imm,
                             output logic [63:0] res, output logic [3:0] flg);
        logic [63:0] a, b;
        logic        c;
        logic [65:0] wide;
        logic signed [65:0] s64;
        logic [33:0] wide32;
        logic signed [33:0] s32;
        b = {{48{imm[15]}}, imm};
        c = 1'b0;
        case (op)
            0: begin a = src; b = b << 16; end
            1: begin a = PC_FIXED + 64'd4; b = b << 16; end
            4: begin a = ~src; c = 1'b1; end
            default: a = src;
        endcase
        wide   = {2'b0, a} + {2'b0, b} + 66'(c);
        wide32 = {2'b0, a[31:0]} + {2'b0, b[31:0]} + 34'(c);
        s64    = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}) + $signed({65'b0, c});
        s32    = $signed({{2{a[31]}}, a[31:0]}) + $signed({{2{b[31]}}, b[31:0]}) + $signed({33'b0, c});
        res    = wide[63:0];
        flg[3] = wide[64];
        flg[2] = wide32[32];
        flg[1] = (s64[65:63] != 3'b000) && (s64[65:63] != 3'b111);
        flg[0] = (s32[33:31] != 3'b000) && (s32[33:31] != 3'b111);
    endtask

    task automatic run_vec(input int op, input logic [63:0] src, input logic [15:0] imm);
        logic [63:0] res;
        logic [3:0]  flg;
        string       rq;
        reference(op, src, imm, res, flg);
        @(negedge clk);
        valid_in = 1'b1;
        instr_in = encode(op, imm);
        src_in   = src;
        pc_in    = PC_FIXED;
        @(posedge clk);
        @(negedge clk);
        valid_in = 1'b0;
        if (op >= 2) m_flags = flg;
        if (op == 3) m_cr = {res[63], !res[63] && res != 0, res == 0, flg[1]};
        rq = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 4) ? "R5" : "R4";
        chk("R1 valid_out", 64'(valid_out), 64'd1);
        chk("R10 no illegal", 64'(illegal_out), 64'd0);
        chk({rq, " result"}, result_out, res);
        chk({rq, " result_we"}, 64'(result_we), 64'd1);
        chk("R9 flags_we", 64'(flags_we), 64'(op >= 2));
        chk("R6 carry pair", 64'({ca_out, ca32_out}), 64'(m_flags[3:2]));
        chk("R7 overflow pair", 64'({ov_out, ov32_out}), 64'(m_flags[1:0]));
        chk("R8 cr_we", 64'(cr_we), 64'(op == 3));
        chk("R8 cond field", 64'({cr_lt, cr_gt, cr_eq, cr_so}), 64'(m_cr));
    endtask

    task automatic raw_cycle(input logic v, input logic [31:0] w);
        @(negedge clk);
        valid_in = v;
        instr_in = w;
        src_in   = 64'h1234;
        pc_in    = PC_FIXED;
        @(posedge clk);
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_flags  = '0;
        m_cr     = '0;
        rst      = 1'b1;
        valid_in = 1'b1;
        instr_in = 32'h3464_0001;
        src_in   = '1;
        pc_in    = PC_FIXED;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset valid_out", 64'(valid_out), 64'd0);
        chk("R1 reset enables", 64'({result_we, flags_we, cr_we, illegal_out}), 64'd0);
        chk("R1 reset result", result_out, 64'd0);
        chk("R1 reset held outputs", 64'({ca_out, ca32_out, ov_out, ov32_out, cr_lt, cr_gt, cr_eq, cr_so}), 64'd0);
        rst      = 1'b0;
        valid_in = 1'b0;

        for (int o = 0; o < 5; o++)
            for (int s = 0; s < 3; s++)
                for (int i = 0; i < 6; i++)
                    run_vec(o, SRC_VALS[s], IMM_VALS[i]);

        // R1 idle cycle writes nothing
        raw_cycle(1'b0, 32'h3464_0001);
        chk("R1 idle valid_out", 64'(valid_out), 64'd0);
        chk("R1 idle enables", 64'({result_we, flags_we, cr_we}), 64'd0);
        chk("R8 idle cond held", 64'({cr_lt, cr_gt, cr_eq, cr_so}), 64'(m_cr));

        // R10 unknown opcode and add-PC with wrong extended field
        raw_cycle(1'b1, 32'h7C00_0000);
        chk("R10 illegal opcode flag", 64'(illegal_out), 64'd1);
        chk("R10 illegal enables", 64'({result_we, flags_we, cr_we}), 64'd0);
        raw_cycle(1'b1, 32'h4C60_0000);
        chk("R10 bad extended field", 64'(illegal_out), 64'd1);
        chk("R10 bad ext enables", 64'({result_we, flags_we, cr_we}), 64'd0);

        // R3 negative assembled value: d = 0x8000 sits in instr bit 15
        raw_cycle(1'b1, 32'h4C60_8004);
        chk("R3 negative add-PC", result_out, 64'hFFFF_FFFF_8000_1004);
        raw_cycle(1'b1, 32'h4C60_0005);
        chk("R3 low bit from instr bit 0", result_out, 64'h0000_0000_0001_1004);

        // R7 64-bit overflow without 32-bit overflow, record form
        @(negedge clk);
        valid_in = 1'b1; instr_in = 32'h3464_0001; src_in = 64'h7FFF_FFFF_FFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        valid_in = 1'b0;
        chk("R4 max plus one", result_out, 64'h8000_0000_0000_0000);
        chk("R7 ov set ov32 clear", 64'({ov_out, ov32_out}), 64'b10);
        chk("R6 ca clear ca32 set", 64'({ca_out, ca32_out}), 64'b01);
        chk("R8 lt with so", 64'({cr_lt, cr_gt, cr_eq, cr_so}), 64'b1001);

        // R5 subtract zero from zero: carry out of both halves, equal untouched
        @(negedge clk);
        valid_in = 1'b1; instr_in = 32'h2064_0000; src_in = 64'h0;
        @(posedge clk);
        @(negedge clk);
        valid_in = 1'b0;
        chk("R5 zero minus zero", result_out, 64'h0);
        chk("R6 subtract carries", 64'({ca_out, ca32_out}), 64'b11);
        chk("R8 cond not written", 64'({cr_we, cr_lt, cr_gt, cr_eq, cr_so}), 64'b01001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule